// File: doc/BRIEF.md
# Dual-Channel Steered Configuration Register Bank

This block holds the configuration state of a two-channel signal generator. A serial front end that has already been decoded delivers byte writes, each carrying a register address, a data byte and the position of that byte within the register's transfer. Multi-byte registers are put together from these bytes and committed when the last byte arrives. Every buffered register has a shadow copy that receives writes and an active copy that drives the outputs. A one-cycle update strobe moves all shadow copies into their active copies in the same cycle.

The per-channel registers exist twice, once for each channel, and both copies sit at the same address. A channel-select register holds a two-bit enable mask that decides which copy receives a committed write. That register, together with the serial-mode and bit-order fields it holds, takes effect right after it is written and does not wait for the update strobe. The control register also carries a clock multiplier field, and the block reports whether that value enables the clock multiplier loop or bypasses it.

Top module: `cfg_bank_top`

## Requirements
- R1: After reset the channel mask is 11, the serial mode is 00, LSB-first is 0, every control-register field and the loop-enable flag are 0, and all channel frequency and phase words are 0.
- R2: A write of byte index 0 to address 0x00 sets the channel mask from data bits 7:6, the serial mode from bits 2:1 and LSB-first from bit 0. The new values are visible on the cycle after the write, with no update strobe.
- R3: When a per-channel register (frequency word at 0x04, four bytes; phase word at 0x05, two bytes) is committed, mask 01 loads only the channel 0 copy, 10 only the channel 1 copy, and 11 loads both copies with the same value.
- R4: A per-channel commit while the mask is 00 changes no channel register and raises drop_o for exactly the one cycle after the final byte.
- R5: Byte index 0 carries the most significant byte. A register is committed only when its final index arrives (2 for address 0x01, 3 for 0x04, 1 for 0x05); earlier bytes alone leave the register as it was.
- R6: Buffered outputs (control fields, loop-enable, frequency and phase words) change only on the cycle after upd_i, and all of them change on that same cycle.
- R7: The control register at 0x01 is 24 bits wide. Bit 23 drives vco_high_o, bits 22:18 drive pll_mult_o, bits 17:16 drive cp_sel_o and bit 7 drives ref_pd_o.
- R8: pll_en_o is 1 exactly when the active multiplier lies in 4..20 inclusive, and 0 for 3 and for 21.
- R9: Writes to addresses other than 0x00, 0x01, 0x04 and 0x05, and bytes whose index exceeds the register's final index, change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Byte write strobe |
| wr_addr_i | input | ADDR_W | Register address |
| wr_idx_i | input | IDX_W | Byte position within the transfer, 0 first |
| wr_data_i | input | 8 | Data byte |
| upd_i | input | 1 | Shadow-to-active update strobe |
| chan_mask_o | output | NUM_CH | Channel write-enable mask |
| ser_mode_o | output | 2 | Serial mode field |
| lsb_first_o | output | 1 | Bit-order select |
| vco_high_o | output | 1 | Oscillator range select |
| pll_mult_o | output | 5 | Clock multiplier value |
| pll_en_o | output | 1 | Multiplier loop enabled |
| cp_sel_o | output | 2 | Charge pump setting |
| ref_pd_o | output | 1 | Reference input power-down |
| freq_o | output | NUM_CH*FREQ_W | Active frequency words, channel 0 in the low bits |
| phase_o | output | NUM_CH*PHASE_W | Active phase words, channel 0 in the low bits |
| drop_o | output | 1 | Pulse for a per-channel write discarded under mask 00 |

## Verification
A wrong mask or a wrong steering decision lands a value in the wrong channel copy, but it stays hidden in the shadow until the next update strobe; after that it shows on freq_o or phase_o one cycle later. A shadow that leaks into the active copy early shows on the buffered outputs before any strobe, so each check reads them both before and after the update. A mis-decoded multiplier boundary shows on pll_en_o in the cycle after the update. The multiplier is swept across 3, 4, 20 and 21 to cover both edges.

// File: rtl/cfg_bank_pkg.sv
package cfg_bank_pkg;
  localparam int ADDR_CSR   = 0;
  localparam int ADDR_CTRL  = 1;
  localparam int ADDR_FREQ  = 4;
  localparam int ADDR_PHASE = 5;

  localparam int VCO_BIT   = 23;
  localparam int MULT_LO   = 18;
  localparam int MULT_W    = 5;
  localparam int CP_LO     = 16;
  localparam int REFPD_BIT = 7;

  localparam int PLL_MIN = 4;
  localparam int PLL_MAX = 20;

  function automatic logic mult_in_range(input logic [MULT_W-1:0] m);
    return (int'(m) >= PLL_MIN) && (int'(m) <= PLL_MAX);
  endfunction
endpackage

// File: rtl/cfg_byte_asm.sv
module cfg_byte_asm #(
  parameter int MAX_BYTES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   byte_we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [IDX_W-1:0]       last_idx,
  input  logic [7:0]             data,
  output logic [8*MAX_BYTES-1:0] word_o
);
  logic [8*MAX_BYTES-1:0] stage_q;
  logic [IDX_W-1:0]       pos;

  // first byte in transfer order is the most significant one
  assign pos = last_idx - idx;

  always_comb begin
    word_o = stage_q;
    word_o[8*pos +: 8] = data;
  end

  always_ff @(posedge clk) begin
    if (rst)          stage_q <= '0;
    else if (byte_we) stage_q <= word_o;
  end
endmodule

// File: rtl/cfg_dbl_reg.sv
module cfg_dbl_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         upd,
  output logic [W-1:0] active_o
);
  logic [W-1:0] shadow_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      active_o <= '0;
    end else begin
      if (ld)  shadow_q <= ld_val;
      if (upd) active_o <= shadow_q;
    end
  end
endmodule

// File: rtl/cfg_bank_top.sv
module cfg_bank_top
  import cfg_bank_pkg::*;
#(
  parameter int ADDR_W  = 5,
  parameter int IDX_W   = 2,
  parameter int NUM_CH  = 2,
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16,
  parameter int CTRL_W  = 24
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en_i,
  input  logic [ADDR_W-1:0]         wr_addr_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [7:0]                wr_data_i,
  input  logic                      upd_i,
  output logic [NUM_CH-1:0]         chan_mask_o,
  output logic [1:0]                ser_mode_o,
  output logic                      lsb_first_o,
  output logic                      vco_high_o,
  output logic [MULT_W-1:0]         pll_mult_o,
  output logic                      pll_en_o,
  output logic [1:0]                cp_sel_o,
  output logic                      ref_pd_o,
  output logic [NUM_CH*FREQ_W-1:0]  freq_o,
  output logic [NUM_CH*PHASE_W-1:0] phase_o,
  output logic                      drop_o
);
  localparam int WORD_W      = (FREQ_W > CTRL_W) ? FREQ_W : CTRL_W;
  localparam int MAX_BYTES   = WORD_W / 8;
  localparam int CTRL_BYTES  = CTRL_W / 8;
  localparam int FREQ_BYTES  = FREQ_W / 8;
  localparam int PHASE_BYTES = PHASE_W / 8;
  localparam int CTRL_KEEP   = 1 + MULT_W + 2 + 1;

  logic             sel_csr, sel_ctrl, sel_freq, sel_phase, known;
  logic [IDX_W-1:0] last_idx;
  logic             byte_ok, fin, chan_fin;
  logic [WORD_W-1:0] asm_word;
  logic [CTRL_KEEP-1:0] ctrl_act;
  logic             pll_sh_q;

  always_comb begin
    sel_csr   = 1'b0;
    sel_ctrl  = 1'b0;
    sel_freq  = 1'b0;
    sel_phase = 1'b0;
    known     = 1'b1;
    last_idx  = '0;
    case (int'(wr_addr_i))
      ADDR_CSR:   sel_csr = 1'b1;
      ADDR_CTRL:  begin sel_ctrl  = 1'b1; last_idx = IDX_W'(CTRL_BYTES - 1);  end
      ADDR_FREQ:  begin sel_freq  = 1'b1; last_idx = IDX_W'(FREQ_BYTES - 1);  end
      ADDR_PHASE: begin sel_phase = 1'b1; last_idx = IDX_W'(PHASE_BYTES - 1); end
      default:    known = 1'b0;
    endcase
  end

  assign byte_ok  = wr_en_i && known && (wr_idx_i <= last_idx);
  assign fin      = byte_ok && (wr_idx_i == last_idx);
  assign chan_fin = fin && (sel_freq || sel_phase);

  cfg_byte_asm #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_asm (
    .clk      (clk),
    .rst      (rst),
    .byte_we  (byte_ok),
    .idx      (wr_idx_i),
    .last_idx (last_idx),
    .data     (wr_data_i),
    .word_o   (asm_word)
  );

  // channel-select register: applies without the update strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      chan_mask_o <= '1;
      ser_mode_o  <= 2'b00;
      lsb_first_o <= 1'b0;
    end else if (fin && sel_csr) begin
      chan_mask_o <= wr_data_i[7 -: NUM_CH];
      ser_mode_o  <= wr_data_i[2:1];
      lsb_first_o <= wr_data_i[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) drop_o <= 1'b0;
    else     drop_o <= chan_fin && (chan_mask_o == '0);
  end

  // control register keeps only the fields it exports
  cfg_dbl_reg #(.W(CTRL_KEEP)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .ld       (fin && sel_ctrl),
    .ld_val   ({asm_word[VCO_BIT], asm_word[MULT_LO +: MULT_W],
                asm_word[CP_LO +: 2], asm_word[REFPD_BIT]}),
    .upd      (upd_i),
    .active_o (ctrl_act)
  );

  assign vco_high_o = ctrl_act[CTRL_KEEP-1];
  assign pll_mult_o = ctrl_act[3 +: MULT_W];
  assign cp_sel_o   = ctrl_act[2:1];
  assign ref_pd_o   = ctrl_act[0];

  // loop-enable flag decoded at load time, moved with the update
  always_ff @(posedge clk) begin
    if (rst) begin
      pll_sh_q <= 1'b0;
      pll_en_o <= 1'b0;
    end else begin
      if (fin && sel_ctrl) pll_sh_q <= mult_in_range(asm_word[MULT_LO +: MULT_W]);
      if (upd_i)           pll_en_o <= pll_sh_q;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cfg_dbl_reg #(.W(FREQ_W)) u_freq (
      .clk      (clk),
      .rst      (rst),
      .ld       (fin && sel_freq && chan_mask_o[c]),
      .ld_val   (asm_word[FREQ_W-1:0]),
      .upd      (upd_i),
      .active_o (freq_o[c*FREQ_W +: FREQ_W])
    );
    cfg_dbl_reg #(.W(PHASE_W)) u_phase (
      .clk      (clk),
      .rst      (rst),
      .ld       (fin && sel_phase && chan_mask_o[c]),
      .ld_val   (asm_word[PHASE_W-1:0]),
      .upd      (upd_i),
      .active_o (phase_o[c*PHASE_W +: PHASE_W])
    );
  end
endmodule

// File: rtl/cfg_bank_chk.sv
module cfg_bank_chk #(
  parameter int ADDR_W  = 5,
  parameter int IDX_W   = 2,
  parameter int NUM_CH  = 2,
  parameter int FREQ_W  = 32,
  parameter int PHASE_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      wr_en_i,
  input logic [ADDR_W-1:0]         wr_addr_i,
  input logic [IDX_W-1:0]          wr_idx_i,
  input logic [NUM_CH-1:0]         mask_bits,
  input logic                      upd_i,
  input logic [NUM_CH-1:0]         chan_mask_o,
  input logic                      vco_high_o,
  input logic [4:0]                pll_mult_o,
  input logic                      pll_en_o,
  input logic [1:0]                cp_sel_o,
  input logic                      ref_pd_o,
  input logic [NUM_CH*FREQ_W-1:0]  freq_o,
  input logic [NUM_CH*PHASE_W-1:0] phase_o,
  input logic                      drop_o
);
  assert_mask_now_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wr_addr_i == '0 && wr_idx_i == '0) |=> chan_mask_o == $past(mask_bits));

  assert_hold_no_update_R6: assert property (@(posedge clk) disable iff (rst)
    !upd_i |=> ($stable(freq_o) && $stable(phase_o) && $stable(pll_mult_o) &&
                $stable(pll_en_o) && $stable(vco_high_o) && $stable(cp_sel_o) &&
                $stable(ref_pd_o)));

  assert_loop_range_R8: assert property (@(posedge clk) disable iff (rst)
    pll_en_o == (pll_mult_o >= 5'd4 && pll_mult_o <= 5'd20));

  assert_drop_mask_R4: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> $past(chan_mask_o) == '0);

  assert_drop_needs_write_R4: assert property (@(posedge clk) disable iff (rst)
    drop_o |-> $past(wr_en_i));
endmodule

bind cfg_bank_top cfg_bank_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_CH(NUM_CH), .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en_i     (wr_en_i),
  .wr_addr_i   (wr_addr_i),
  .wr_idx_i    (wr_idx_i),
  .mask_bits   (wr_data_i[7 -: NUM_CH]),
  .upd_i       (upd_i),
  .chan_mask_o (chan_mask_o),
  .vco_high_o  (vco_high_o),
  .pll_mult_o  (pll_mult_o),
  .pll_en_o    (pll_en_o),
  .cp_sel_o    (cp_sel_o),
  .ref_pd_o    (ref_pd_o),
  .freq_o      (freq_o),
  .phase_o     (phase_o),
  .drop_o      (drop_o)
);

// File: tb/tb_cfg_bank_top.sv
module tb_cfg_bank_top;
  localparam int ADDR_W = 5, IDX_W = 2, NUM_CH = 2, FREQ_W = 32, PHASE_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [IDX_W-1:0]  wr_idx = '0;
  logic [7:0]        wr_data = '0;
  logic              upd = 1'b0;
  logic [NUM_CH-1:0] chan_mask;
  logic [1:0]        ser_mode, cp_sel;
  logic              lsb_first, vco_high, pll_en, ref_pd, drop;
  logic [4:0]        pll_mult;
  logic [NUM_CH*FREQ_W-1:0]  freq;
  logic [NUM_CH*PHASE_W-1:0] phase;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int          q_sel[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];

  always #5 clk = ~clk;

  cfg_bank_top #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NUM_CH(NUM_CH),
                 .FREQ_W(FREQ_W), .PHASE_W(PHASE_W)) dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .upd_i(upd), .chan_mask_o(chan_mask), .ser_mode_o(ser_mode),
    .lsb_first_o(lsb_first), .vco_high_o(vco_high), .pll_mult_o(pll_mult),
    .pll_en_o(pll_en), .cp_sel_o(cp_sel), .ref_pd_o(ref_pd), .freq_o(freq),
    .phase_o(phase), .drop_o(drop)
  );

  function automatic logic [31:0] observe(input int sel);
    case (sel)
      0:  return 32'(chan_mask);
      1:  return 32'(ser_mode);
      2:  return 32'(lsb_first);
      3:  return 32'(vco_high);
      4:  return 32'(pll_mult);
      5:  return 32'(cp_sel);
      6:  return 32'(ref_pd);
      7:  return 32'(pll_en);
      8:  return 32'(drop);
      9:  return freq[31:0];
      10: return freq[63:32];
      11: return 32'(phase[15:0]);
      12: return 32'(phase[31:16]);
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  // monitor: pops expected items and compares just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_sel.size() > 0) begin
        int s;
        logic [31:0] e, a;
        string t;
        s = q_sel.pop_front();
        e = q_exp.pop_front();
        t = q_tag.pop_front();
        a = observe(s);
        n_checks++;
        if (a !== e) begin
          n_fail++;
          $display("FAIL %s (output %0d): actual 0x%0h expected 0x%0h", t, s, a, e);
        end
      end
    end
  end

  task automatic expect_out(input int sel, input logic [31:0] val, input string tag);
    q_sel.push_back(sel);
    q_exp.push_back(val);
    q_tag.push_back(tag);
  endtask

  task automatic wr(input int addr, input int idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = ADDR_W'(addr); wr_idx = IDX_W'(idx); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wr_word(input int addr, input int nbytes, input logic [31:0] v);
    for (int i = 0; i < nbytes; i++) wr(addr, i, v[8*(nbytes-1-i) +: 8]);
  endtask

  task automatic pulse_upd();
    @(negedge clk);
    upd = 1'b1;
    @(negedge clk);
    upd = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] ctrl_val(input bit v, input int m, input int cp, input bit pd);
    return {8'h00, v, 5'(m), 2'(cp), 8'h00, pd, 7'h00};
  endfunction

  task automatic check_mult(input int m, input bit en, input string tag);
    wr_word(1, 3, ctrl_val(1'b0, m, 0, 1'b0));
    pulse_upd();
    expect_out(4, 32'(m), tag);
    expect_out(7, 32'(en), tag);
    settle();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    expect_out(0, 32'h3, "R1 mask");
    expect_out(1, 32'h0, "R1 mode");
    expect_out(2, 32'h0, "R1 lsb");
    expect_out(3, 32'h0, "R1 vco");
    expect_out(4, 32'h0, "R1 mult");
    expect_out(5, 32'h0, "R1 cp");
    expect_out(6, 32'h0, "R1 refpd");
    expect_out(7, 32'h0, "R1 pll_en");
    expect_out(9, 32'h0, "R1 freq0");
    expect_out(10, 32'h0, "R1 freq1");
    expect_out(12, 32'h0, "R1 phase1");
    settle();

    // R2: mask 01, mode 11, lsb 1 (bit 3 kept 0)
    wr(0, 0, 8'h47);
    expect_out(0, 32'h1, "R2 mask");
    expect_out(1, 32'h3, "R2 mode");
    expect_out(2, 32'h1, "R2 lsb");
    settle();

    // R3/R6: channel 0 only
    wr_word(4, 4, 32'h1122_3344);
    expect_out(9, 32'h0, "R6 freq0 before update");
    settle();
    pulse_upd();
    expect_out(9, 32'h1122_3344, "R3 mask01 freq0");
    expect_out(10, 32'h0, "R3 mask01 freq1");
    settle();

    // R3: channel 1 only
    wr(0, 0, 8'h80);
    wr_word(4, 4, 32'hAABB_CCDD);
    pulse_upd();
    expect_out(9, 32'h1122_3344, "R3 mask10 freq0");
    expect_out(10, 32'hAABB_CCDD, "R3 mask10 freq1");
    settle();

    // R3: both channels, phase word
    wr(0, 0, 8'hC0);
    wr_word(5, 2, 32'h0000_1234);
    pulse_upd();
    expect_out(11, 32'h1234, "R3 mask11 phase0");
    expect_out(12, 32'h1234, "R3 mask11 phase1");
    settle();

    // R4: mask 00 discards and pulses drop
    wr(0, 0, 8'h00);
    wr_word(4, 4, 32'hDEAD_BEEF);
    expect_out(8, 32'h1, "R4 drop pulse");
    settle();
    expect_out(8, 32'h0, "R4 drop one cycle");
    pulse_upd();
    expect_out(9, 32'h1122_3344, "R4 freq0 kept");
    expect_out(10, 32'hAABB_CCDD, "R4 freq1 kept");
    settle();

    // R5: partial transfer never commits
    wr(0, 0, 8'hC0);
    wr(4, 0, 8'h55);
    wr(4, 1, 8'h66);
    pulse_upd();
    expect_out(9, 32'h1122_3344, "R5 partial freq0");
    expect_out(10, 32'hAABB_CCDD, "R5 partial freq1");
    settle();

    // R9: unknown address and out-of-range index
    wr(2, 0, 8'h3C);
    wr(5, 3, 8'h99);
    wr(7, 0, 8'hFF);
    pulse_upd();
    expect_out(11, 32'h1234, "R9 phase0 unchanged");
    expect_out(0, 32'h3, "R9 mask unchanged");
    settle();

    // R7/R6: control fields
    wr_word(1, 3, ctrl_val(1'b1, 4, 2, 1'b1));
    expect_out(3, 32'h0, "R6 vco before update");
    expect_out(7, 32'h0, "R6 pll_en before update");
    settle();
    pulse_upd();
    expect_out(3, 32'h1, "R7 vco");
    expect_out(4, 32'h4, "R7 mult");
    expect_out(5, 32'h2, "R7 cp");
    expect_out(6, 32'h1, "R7 refpd");
    expect_out(7, 32'h1, "R8 pll_en at 4");
    settle();

    // R8: boundaries
    check_mult(3, 1'b0, "R8 mult 3");
    check_mult(4, 1'b1, "R8 mult 4");
    check_mult(20, 1'b1, "R8 mult 20");
    check_mult(21, 1'b0, "R8 mult 21");

    settle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule